// File: doc/BRIEF.md
# Multicycle Unsigned Non-Restoring Divider

This block divides an unsigned N-bit dividend by an unsigned N-bit divisor. It produces one quotient bit per clock. The partial remainder and the quotient share a combined shift register. On each step the remainder half takes either a subtraction or an addition of the divisor, and the choice follows the sign the remainder was left with by the previous step. No cycle is spent restoring a negative value. After the last step, a single correction cycle adds the divisor back if the remainder is still negative. The remainder half is one bit wider than N, so its sign is never lost.

A client raises `start` for one cycle with the operands present. `busy` then stays high while the division runs. `done` pulses for one cycle when the registered quotient and remainder are valid, and those results hold until the next completion. A zero divisor takes a short path. It raises a flag, returns an all-ones quotient, and returns the dividend as the remainder.

Top module: `nrDivider`

## Requirements
- R1: For a non-zero divisor, `quotient` equals the integer floor of dividend / divisor once `done` pulses.
- R2: For a non-zero divisor, `remainder` equals dividend mod divisor, so it is always strictly below the divisor.
- R3: `done` is high for exactly one cycle. With a non-zero divisor it is first seen N+2 rising edges after the edge that samples `start`, counting that edge as the first.
- R4: `busy` is high from the edge that accepts `start` until the edge that raises `done`. `busy` and `done` are never high together.
- R5: A `start` pulse raised while `busy` is high is ignored: the running division completes with its original operands.
- R6: A zero divisor gives `divByZero` = 1, a quotient of all ones and a remainder equal to the dividend, with `done` on the 2nd edge. The next division by a non-zero value clears `divByZero`.
- R7: `quotient`, `remainder` and `divByZero` keep their values from one completion until the next.
- R8: After reset, `busy`, `done`, `divByZero`, `quotient` and `remainder` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | One-cycle request; accepted only while idle |
| dividend | input | WIDTH | Unsigned dividend, sampled with start |
| divisor | input | WIDTH | Unsigned divisor, sampled with start |
| busy | output | 1 | A division is in progress |
| done | output | 1 | One-cycle pulse: results valid |
| quotient | output | WIDTH | Registered quotient |
| remainder | output | WIDTH | Registered non-negative remainder |
| divByZero | output | 1 | Last completed division had a zero divisor |

## Verification
A wrong add/subtract choice, a wrong quotient bit or a lost sign bit in the partial remainder cannot hide. It leaves wrong quotient or remainder values at the next `done`, at most N+2 cycles after the start. The cases that make the remainder go negative in the last step are where a missing correction shows up as a remainder at or above the divisor. Directed cases at the operand extremes cover the points where an undersized remainder register would wrap. A fault in the step counter shows up as a `done` that arrives on the wrong cycle. A fault in the start guard shows up as a result computed from the operands of an ignored request.

// File: rtl/nrDivPkg.sv
package nrDivPkg;

  typedef struct packed {
    logic load;    // capture operands, clear remainder half
    logic step;    // one shift plus add/subtract iteration
    logic finish;  // correction and output register update
  } divStrobeT;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_FIX  = 2'd2
  } divStateT;

endpackage

// File: rtl/nrDivDatapath.sv
module nrDivDatapath
  import nrDivPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobeT        strobe,
  input  logic [WIDTH-1:0] dividendIn,
  input  logic [WIDTH-1:0] divisorIn,
  output logic             divisorInZero,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             divByZero
);

  localparam int REM_W = WIDTH + 1;

  logic [REM_W-1:0] remReg;
  logic [WIDTH-1:0] quoReg;
  logic [WIDTH-1:0] divReg;
  logic             zeroHeld;

  logic [REM_W-1:0] divExt;
  logic [REM_W-1:0] shiftedRem;
  logic [REM_W-1:0] nextRem;
  logic [REM_W-1:0] fixedRem;

  assign divisorInZero = (divisorIn == '0);
  assign divExt        = {1'b0, divReg};

  // Shift the combined register left by one: the MSB of the quotient half
  // moves into the LSB of the remainder half.
  assign shiftedRem = {remReg[REM_W-2:0], quoReg[WIDTH-1]};

  // Sign of the remainder left by the previous step picks the operation.
  always_comb begin
    if (remReg[REM_W-1]) nextRem = shiftedRem + divExt;
    else                 nextRem = shiftedRem - divExt;
  end

  // Final correction: one add-back when the last remainder is negative.
  always_comb begin
    if (remReg[REM_W-1]) fixedRem = remReg + divExt;
    else                 fixedRem = remReg;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      remReg   <= '0;
      quoReg   <= '0;
      divReg   <= '0;
      zeroHeld <= 1'b0;
    end else if (strobe.load) begin
      remReg   <= '0;
      quoReg   <= dividendIn;
      divReg   <= divisorIn;
      zeroHeld <= divisorInZero;
    end else if (strobe.step) begin
      remReg   <= nextRem;
      quoReg   <= {quoReg[WIDTH-2:0], ~nextRem[REM_W-1]};
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quotient  <= '0;
      remainder <= '0;
      divByZero <= 1'b0;
    end else if (strobe.finish) begin
      divByZero <= zeroHeld;
      if (zeroHeld) begin
        quotient  <= '1;
        remainder <= quoReg;   // no steps ran: still the dividend
      end else begin
        quotient  <= quoReg;
        remainder <= fixedRem[WIDTH-1:0];
      end
    end
  end

  // R2: a completed non-zero division leaves a remainder below the divisor
  a_r2_rem_below_divisor: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && !zeroHeld) |=> (remainder < divReg));

  // R6: zero divisor yields an all-ones quotient and the flag
  a_r6_zero_result: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.finish && zeroHeld) |=> (divByZero && (&quotient)));

  // R7: results do not move between completions
  a_r7_results_hold: assert property (@(posedge clk) disable iff (!rstN)
    !strobe.finish |=> ($stable(quotient) && $stable(remainder) && $stable(divByZero)));

  // R5: operands are never recaptured while an iteration is due
  a_r5_single_strobe: assert property (@(posedge clk) disable iff (!rstN)
    $countones({strobe.load, strobe.step, strobe.finish}) <= 1);

endmodule

// File: rtl/nrDivControl.sv
module nrDivControl
  import nrDivPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      start,
  input  logic      divisorInZero,
  output divStrobeT strobe,
  output logic      busy,
  output logic      done
);

  localparam int CNT_W = $clog2(WIDTH + 1);
  localparam logic [CNT_W-1:0] LAST_STEP = CNT_W'(WIDTH - 1);

  divStateT         state;
  divStateT         stateNext;
  logic [CNT_W-1:0] stepCnt;

  always_comb begin
    strobe    = '0;
    stateNext = state;
    unique case (state)
      ST_IDLE: begin
        if (start) begin
          strobe.load = 1'b1;
          stateNext   = divisorInZero ? ST_FIX : ST_RUN;
        end
      end
      ST_RUN: begin
        strobe.step = 1'b1;
        if (stepCnt == LAST_STEP) stateNext = ST_FIX;
      end
      ST_FIX: begin
        strobe.finish = 1'b1;
        stateNext     = ST_IDLE;
      end
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state   <= ST_IDLE;
      stepCnt <= '0;
      done    <= 1'b0;
    end else begin
      state <= stateNext;
      done  <= strobe.finish;
      if (strobe.load)      stepCnt <= '0;
      else if (strobe.step) stepCnt <= stepCnt + 1'b1;
    end
  end

  assign busy = (state != ST_IDLE);

  // R3: done lasts one cycle
  a_r3_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R4: busy and done are exclusive
  a_r4_busy_done_excl: assert property (@(posedge clk) disable iff (!rstN)
    !(busy && done));

  // R4: an accepted start raises busy on the next cycle
  a_r4_start_busy: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);

  // R3: the step counter never passes the operand width
  a_r3_step_bound: assert property (@(posedge clk) disable iff (!rstN)
    strobe.step |-> (stepCnt <= LAST_STEP));

endmodule

// File: rtl/nrDivider.sv
module nrDivider
  import nrDivPkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder,
  output logic             divByZero
);

  divStrobeT strobe;
  logic      divisorInZero;

  nrDivControl #(.WIDTH(WIDTH)) ctrl_i (
    .clk          (clk),
    .rstN         (rstN),
    .start        (start),
    .divisorInZero(divisorInZero),
    .strobe       (strobe),
    .busy         (busy),
    .done         (done)
  );

  nrDivDatapath #(.WIDTH(WIDTH)) dp_i (
    .clk          (clk),
    .rstN         (rstN),
    .strobe       (strobe),
    .dividendIn   (dividend),
    .divisorIn    (divisor),
    .divisorInZero(divisorInZero),
    .quotient     (quotient),
    .remainder    (remainder),
    .divByZero    (divByZero)
  );

endmodule

// File: tb/nrDivider_tb_top.sv
module nrDivider_tb_top;

  localparam int W = 8;

  logic         clk = 1'b0;
  logic         rstN = 1'b0;
  logic         start = 1'b0;
  logic [W-1:0] dividend = '0;
  logic [W-1:0] divisor = '0;
  logic         busy, done, divByZero;
  logic [W-1:0] quotient, remainder;

  int testCount = 0;
  int failCount = 0;
  int cycleCount = 0;

  always #4 clk = ~clk;   // 125 MHz

  nrDivider #(.WIDTH(W)) dut_i (
    .clk(clk), .rstN(rstN), .start(start),
    .dividend(dividend), .divisor(divisor),
    .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder), .divByZero(divByZero)
  );

  always @(posedge clk) begin
    cycleCount <= cycleCount + 1;
    if (cycleCount > 150000) begin
      failCount = failCount + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected < 150000", cycleCount);
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  function automatic logic [W-1:0] expQuo(logic [W-1:0] a, logic [W-1:0] b);
    return (b == 0) ? '1 : a / b;
  endfunction

  function automatic logic [W-1:0] expRem(logic [W-1:0] a, logic [W-1:0] b);
    return (b == 0) ? a : a % b;
  endfunction

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    testCount = testCount + 1;
    if (act !== exp) begin
      failCount = failCount + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // Issue one division; returns the number of rising edges from the
  // accepting edge up to and including the one that raised done.
  task automatic runDiv(input logic [W-1:0] a, input logic [W-1:0] b,
                        input bit injectStart, output int edges);
    @(negedge clk);
    dividend = a; divisor = b; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    edges = 1;
    chk("R4 busy after start", busy, 1);
    while (!done && edges < 4 * W) begin
      if (injectStart && edges == 2) begin
        start = 1'b1; dividend = ~a; divisor = b ^ 8'h5A;
      end else begin
        start = 1'b0;
      end
      @(negedge clk);
      edges = edges + 1;
      if (!done) chk("R4 busy while running", busy, 1);
    end
    start = 1'b0;
    chk("R4 busy low with done", busy, 0);
  endtask

  task automatic checkResult(logic [W-1:0] a, logic [W-1:0] b, int edges);
    chk("R1 quotient", quotient, expQuo(a, b));
    chk("R2 remainder", remainder, expRem(a, b));
    chk("R6 flag", divByZero, (b == 0));
    chk("R3 latency", edges, (b == 0) ? 2 : W + 2);
  endtask

  initial begin
    int edges;
    logic [W-1:0] a, b;
    void'($urandom(32'd2024));

    #20;
    chk("R8 busy reset", busy, 0);
    chk("R8 done reset", done, 0);
    chk("R8 quotient reset", quotient, 0);
    chk("R8 remainder reset", remainder, 0);
    chk("R8 flag reset", divByZero, 0);
    @(negedge clk);
    rstN = 1'b1;

    // directed cases
    runDiv(8'd7, 8'd2, 0, edges);     checkResult(8'd7, 8'd2, edges);
    @(negedge clk);
    chk("R3 done single cycle", done, 0);
    runDiv(8'd255, 8'd1, 0, edges);   checkResult(8'd255, 8'd1, edges);
    runDiv(8'd255, 8'd255, 0, edges); checkResult(8'd255, 8'd255, edges);
    runDiv(8'd0, 8'd5, 0, edges);     checkResult(8'd0, 8'd5, edges);
    runDiv(8'd5, 8'd7, 0, edges);     checkResult(8'd5, 8'd7, edges);
    runDiv(8'd128, 8'd3, 0, edges);   checkResult(8'd128, 8'd3, edges);
    runDiv(8'd254, 8'd255, 0, edges); checkResult(8'd254, 8'd255, edges);
    runDiv(8'd255, 8'd128, 0, edges); checkResult(8'd255, 8'd128, edges);

    // R6: zero divisor, then flag clears
    runDiv(8'd200, 8'd0, 0, edges);   checkResult(8'd200, 8'd0, edges);
    runDiv(8'd0, 8'd0, 0, edges);     checkResult(8'd0, 8'd0, edges);
    runDiv(8'd9, 8'd4, 0, edges);     checkResult(8'd9, 8'd4, edges);
    chk("R6 flag cleared", divByZero, 0);

    // R7: results hold while idle
    repeat (5) @(negedge clk);
    chk("R7 quotient held", quotient, 8'd2);
    chk("R7 remainder held", remainder, 8'd1);

    // R5: start during busy is ignored
    runDiv(8'd100, 8'd7, 1, edges);   checkResult(8'd100, 8'd7, edges);
    runDiv(8'd13, 8'd200, 1, edges);  checkResult(8'd13, 8'd200, edges);

    // random operands
    for (int i = 0; i < 400; i++) begin
      a = W'($urandom);
      b = W'($urandom);
      if (i % 50 == 0) b = '0;
      runDiv(a, b, (i % 7 == 3), edges);
      checkResult(a, b, edges);
    end

    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end

endmodule